// File: doc/BRIEF.md
# Flag-Setting Add/Subtract Unit

This block is the arithmetic core of an integer execution stage. It adds or subtracts two operands in a single combinational pass. The operation can be plain, or it can chain in a carry flag kept from an earlier instruction. Alongside the sum or difference it produces the four condition flags: negative, zero, carry and overflow.

After a subtraction, the carry flag means "no borrow occurred". Subtract-with-carry therefore takes away one extra unit whenever the incoming carry is clear.

The unit does not store flags. It raises a write-enable output next to the flags, and that enable is set only when the instruction asks for its flags to be written. The flag register outside the block uses this enable.

Top module: `flagAddSub`

## Requirements
- R1: With `opSel` = 2'b00 (add), `result` is `opA + opB` modulo 2^WIDTH, and `flagC` is 1 exactly when `result` is unsigned less than `opA`.
- R2: With `opSel` = 2'b01 (add with carry), `result` is `opA + opB + carryIn`. When `carryIn` is 1, `flagC` is 1 exactly when `result` is unsigned less than or equal to `opA`. When `carryIn` is 0, `flagC` follows the R1 rule.
- R3: With `opSel` = 2'b10 (subtract), `result` is `opA - opB` modulo 2^WIDTH, and `flagC` is 1 exactly when `opA` is unsigned greater than or equal to `opB`.
- R4: With `opSel` = 2'b11 (subtract with carry) and `carryIn` = 0, `result` is `opA - opB - 1`, and `flagC` is 1 exactly when `opA` is unsigned greater than `opB`.
- R5: With `opSel` = 2'b11 and `carryIn` = 1, every output equals the R3 subtract outputs for the same operands.
- R6: For `opSel` 2'b00 and 2'b10, `carryIn` has no effect on any output.
- R7: For the two add codes, `flagV` is 1 exactly when `opA` and `opB` have the same sign bit and the sign bit of `result` differs from that of `opA`.
- R8: For the two subtract codes, `flagV` is 1 exactly when `opA` and `opB` have different sign bits and the sign bit of `result` differs from that of `opA`.
- R9: `flagN` equals the top bit of `result`, and `flagZ` is 1 exactly when every bit of `result` is 0. This holds for every code.
- R10: `flagWe` equals `setFlags`. `setFlags` has no effect on `result` or on the four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Current carry flag |
| opSel | input | 2 | Operation code: 00 add, 01 add with carry, 10 subtract, 11 subtract with carry |
| setFlags | input | 1 | The instruction requests a flag update |
| result | output | WIDTH | Sum or difference |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag (no borrow, for subtraction) |
| flagV | output | 1 | Signed overflow flag |
| flagWe | output | 1 | Write enable for the flags |

## Verification
The bench builds two instances of the block.

The first uses WIDTH = 4. At that width the bench can sweep every operand pair under every operation code, every carry-in value and both flag-enable values. This covers every wrap, borrow, overflow and zero case for each arithmetic rule.

The second uses the default WIDTH = 32. It receives directed vectors at the extreme values, which confirms that the carry and overflow logic scales to the full word.

// File: rtl/flagAddSubPkg.sv
package flagAddSubPkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SUB = 2'b10,
    OP_SBC = 2'b11
  } arithOp_e;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic invertB;   // take the ones' complement of operand B
    logic carryBit;  // carry into the adder LSB
    logic flagWe;    // flag write request
  } addStrobes_t;

endpackage

// File: rtl/flagAddSubCtrl.sv
module flagAddSubCtrl
  import flagAddSubPkg::*;
(
  input  logic [1:0]  opSel,
  input  logic        carryIn,
  input  logic        setFlags,
  output addStrobes_t strobes
);

  arithOp_e op;

  always_comb begin
    op = arithOp_e'(opSel);
    strobes = '0;
    strobes.flagWe = setFlags;
    unique case (op)
      OP_ADD: begin
        strobes.invertB  = 1'b0;
        strobes.carryBit = 1'b0;
      end
      OP_ADC: begin
        strobes.invertB  = 1'b0;
        strobes.carryBit = carryIn;
      end
      OP_SUB: begin
        strobes.invertB  = 1'b1;
        strobes.carryBit = 1'b1;
      end
      OP_SBC: begin
        strobes.invertB  = 1'b1;
        strobes.carryBit = carryIn;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/flagAddSubPath.sv
module flagAddSubPath
  import flagAddSubPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  addStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV,
  output logic             flagWe
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH:0]   wideSum;

  always_comb begin
    bEff    = strobes.invertB ? ~opB : opB;
    wideSum = {1'b0, opA} + {1'b0, bEff} + {{WIDTH{1'b0}}, strobes.carryBit};
    result  = wideSum[MSB:0];
    flagC   = wideSum[WIDTH];
    flagN   = wideSum[MSB];
    flagZ   = ~|wideSum[MSB:0];
    // For a subtraction, bEff carries the inverted sign of B, so a single
    // same-sign test covers both kinds of operation.
    flagV   = (opA[MSB] == bEff[MSB]) && (wideSum[MSB] != opA[MSB]);
    flagWe  = strobes.flagWe;
  end

endmodule

// File: rtl/flagAddSub.sv
module flagAddSub
  import flagAddSubPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic [1:0]       opSel,
  input  logic             setFlags,
  output logic [WIDTH-1:0] result,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV,
  output logic             flagWe
);

  addStrobes_t strobes;

  flagAddSubCtrl ctrl_i (
    .opSel    (opSel),
    .carryIn  (carryIn),
    .setFlags (setFlags),
    .strobes  (strobes)
  );

  flagAddSubPath #(.WIDTH(WIDTH)) path_i (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .flagN   (flagN),
    .flagZ   (flagZ),
    .flagC   (flagC),
    .flagV   (flagV),
    .flagWe  (flagWe)
  );

endmodule

// File: rtl/flagAddSubChecker.sv
module flagAddSubChecker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [1:0]       opSel,
  input logic             setFlags,
  input logic [WIDTH-1:0] result,
  input logic             flagN,
  input logic             flagZ,
  input logic             flagC,
  input logic             flagV,
  input logic             flagWe
);

  localparam int MSB = WIDTH - 1;

  // The block has no clock, so every check is an immediate assertion
  // that is evaluated whenever its inputs change.
  always_comb begin
    if (opSel == 2'b00)
      a_r1_add_carry: assert (flagC == (result < opA));
    if (opSel == 2'b01 && carryIn)
      a_r2_adc_carry: assert (flagC == (result <= opA));
    if (opSel == 2'b10)
      a_r3_sub_carry: assert (flagC == (opA >= opB));
    if (opSel == 2'b11 && !carryIn)
      a_r4_sbc_carry: assert (flagC == (opA > opB));
    if (!opSel[1])
      a_r7_add_ovf: assert (flagV == ((opA[MSB] == opB[MSB]) && (result[MSB] != opA[MSB])));
    if (opSel[1])
      a_r8_sub_ovf: assert (flagV == ((opA[MSB] != opB[MSB]) && (result[MSB] != opA[MSB])));
    a_r9_neg: assert (flagN == result[MSB]);
    a_r9_zero: assert (flagZ == (result == '0));
    a_r10_we: assert (flagWe == setFlags);
  end

endmodule

bind flagAddSub flagAddSubChecker #(.WIDTH(WIDTH)) chk_i (
  .opA      (opA),
  .opB      (opB),
  .carryIn  (carryIn),
  .opSel    (opSel),
  .setFlags (setFlags),
  .result   (result),
  .flagN    (flagN),
  .flagZ    (flagZ),
  .flagC    (flagC),
  .flagV    (flagV),
  .flagWe   (flagWe)
);

// File: tb/flagAddSub_tb_top.sv
module flagAddSub_tb_top;

  localparam int SW = 4;
  localparam int SMASK = (1 << SW) - 1;
  localparam int SHALF = 1 << (SW - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int errCnt = 0;
  int chkCnt = 0;

  // Small instance: swept exhaustively
  logic [SW-1:0] sA, sB, sRes;
  logic sCin, sSetF, sN, sZ, sC, sV, sWe;
  logic [1:0] sOp;

  flagAddSub #(.WIDTH(SW)) dut_i (
    .opA(sA), .opB(sB), .carryIn(sCin), .opSel(sOp), .setFlags(sSetF),
    .result(sRes), .flagN(sN), .flagZ(sZ), .flagC(sC), .flagV(sV), .flagWe(sWe)
  );

  // Full-width instance: directed corners
  logic [31:0] wA, wB, wRes;
  logic wCin, wSetF, wN, wZ, wC, wV, wWe;
  logic [1:0] wOp;

  flagAddSub #(.WIDTH(32)) wideDut_i (
    .opA(wA), .opB(wB), .carryIn(wCin), .opSel(wOp), .setFlags(wSetF),
    .result(wRes), .flagN(wN), .flagZ(wZ), .flagC(wC), .flagV(wV), .flagWe(wWe)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wideCase(input logic [31:0] a, input logic [31:0] b, input logic cin,
                          input logic [1:0] op, input logic [31:0] eRes,
                          input logic eN, input logic eZ, input logic eC, input logic eV,
                          input string req);
    @(negedge clk);
    wA = a; wB = b; wCin = cin; wOp = op; wSetF = 1'b1;
    #1;
    check(wRes == eRes, {req, " wide result"}, wRes, eRes);
    check({wN, wZ, wC, wV} == {eN, eZ, eC, eV}, {req, " wide NZCV"},
          {wN, wZ, wC, wV}, {eN, eZ, eC, eV});
  endtask

  initial begin : watchdog
    #400000;
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    sA = '0; sB = '0; sCin = 1'b0; sOp = 2'b00; sSetF = 1'b0;
    wA = '0; wB = '0; wCin = 1'b0; wOp = 2'b00; wSetF = 1'b0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // Initial state: 0 + 0 with flag writing disabled
    @(negedge clk);
    #1;
    check(sRes == 0 && sZ && !sC && !sV && !sN, "R9 initial", {sRes, sN, sZ, sC, sV}, 4'b0100);
    check(sWe == 1'b0, "R10 initial we", sWe, 0);

    // Exhaustive sweep of the small instance
    for (int op = 0; op < 4; op++) begin
      for (int cin = 0; cin < 2; cin++) begin
        for (int sf = 0; sf < 2; sf++) begin
          for (int a = 0; a < (1 << SW); a++) begin
            for (int b = 0; b < (1 << SW); b++) begin
              int eR, sa, sb, sv;
              bit eC, eV, eN, eZ;
              string req;
              case (op)
                0: begin eR = (a + b) & SMASK; eC = (eR < a); req = cin ? "R1/R6" : "R1"; end
                1: begin
                  if (cin != 0) begin eR = (a + b + 1) & SMASK; eC = (eR <= a); end
                  else begin eR = (a + b) & SMASK; eC = (eR < a); end
                  req = "R2";
                end
                2: begin eR = (a - b) & SMASK; eC = (a >= b); req = cin ? "R3/R6" : "R3"; end
                default: begin
                  if (cin != 0) begin eR = (a - b) & SMASK; eC = (a >= b); req = "R5"; end
                  else begin eR = (a - b - 1) & SMASK; eC = (a > b); req = "R4"; end
                end
              endcase
              sa = (a >= SHALF) ? a - (1 << SW) : a;
              sb = (b >= SHALF) ? b - (1 << SW) : b;
              if (op < 2) sv = sa + sb + ((op == 1 && cin != 0) ? 1 : 0);
              else        sv = sa - sb - ((op == 3 && cin == 0) ? 1 : 0);
              eV = (sv >= SHALF) || (sv < -SHALF);
              eN = (eR >= SHALF);
              eZ = (eR == 0);

              @(negedge clk);
              sA = SW'(a); sB = SW'(b); sCin = cin[0]; sOp = op[1:0]; sSetF = sf[0];
              #1;
              check(int'(sRes) == eR, {req, " result"}, sRes, eR);
              check(sC == eC, {req, " carry"}, sC, eC);
              check(sV == eV, (op < 2) ? "R7 overflow" : "R8 overflow", sV, eV);
              check(sN == eN && sZ == eZ, "R9 N/Z", {sN, sZ}, {eN, eZ});
              check(sWe == sf[0], "R10 flag enable", sWe, sf);
            end
          end
        end
      end
    end

    // Directed corners on the full-width instance
    wideCase(32'hFFFF_FFFF, 32'h1, 1'b0, 2'b00, 32'h0, 0, 1, 1, 0, "R1");
    wideCase(32'h7FFF_FFFF, 32'h1, 1'b0, 2'b00, 32'h8000_0000, 1, 0, 0, 1, "R7");
    wideCase(32'hFFFF_FFFF, 32'h0, 1'b1, 2'b01, 32'h0, 0, 1, 1, 0, "R2");
    wideCase(32'h8000_0000, 32'h1, 1'b0, 2'b10, 32'h7FFF_FFFF, 0, 0, 1, 1, "R8");
    wideCase(32'h5, 32'h5, 1'b0, 2'b11, 32'hFFFF_FFFF, 1, 0, 0, 0, "R4");
    wideCase(32'h5, 32'h5, 1'b1, 2'b11, 32'h0, 0, 1, 1, 0, "R5");
    wideCase(32'h0, 32'h1, 1'b1, 2'b10, 32'hFFFF_FFFF, 1, 0, 0, 0, "R6");
    wideCase(32'h8000_0000, 32'h8000_0000, 1'b0, 2'b00, 32'h0, 0, 1, 1, 1, "R9");

    $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule